// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder via Gray Code

This block takes the thermometer word produced by a bank of 2^N - 1 comparators and turns it into an N-bit binary level. It does not count ones and it does not use a lookup table. Instead it first forms an intermediate Gray word. Each Gray bit below the top one is an OR of paired tap products of the form (lower tap AND NOT upper tap). The top Gray bit is the middle tap itself. A ripple XOR chain running from the MSB down then recovers the binary word from the Gray word.

Each output bit depends only on a few taps, and adjacent levels differ in a single Gray bit. As a result, one comparator that has not settled, or one isolated bubble, disturbs at most the bits tied to its own taps.

Both the Gray word and the binary word are registered in a single pipeline stage. Input and output use valid/ready handshakes:

- A code is accepted on a rising edge when `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the output register holds its contents and `in_ready` is low.
- The producer must then keep `thermo` and `in_valid` stable.

Top module: `thermo_gray_encoder`

## Requirements
- R1: A clean thermometer code, with its k ones in taps T1..Tk and all higher taps zero, produces `bin_q` = k. The all-zero code gives 0 and the all-ones code gives 2^N - 1.
- R2: For every clean code, `gray_q` equals `bin_q` XOR (`bin_q` >> 1). With N = 5, the all-ones code gives Gray 5'b10000.
- R3: The Gray outputs of two adjacent clean levels k and k+1 differ in exactly one bit.
- R4: The top Gray bit and the top binary bit both equal tap T(2^(N-1)). A single bubble set in a tap above that middle tap, over a clean code below the middle tap, leaves both of them 0.
- R5: No bubble correction is applied. For any input, Gray bit i (for i < N-1) is the OR over m of T(2^i + m·2^(i+2)) AND NOT T(2^i + m·2^(i+2) + 2^(i+1)). Binary bit N-1 equals Gray bit N-1, and each lower binary bit i equals Gray bit i XOR binary bit i+1.
- R6: A code accepted on a rising edge appears on `gray_q` and `bin_q`, with `out_valid` high, right after that same edge (one register stage). With `out_ready` high and no input offered, `out_valid` falls after the next edge.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `gray_q`, `bin_q` and `out_valid` hold their values.
- R8: A synchronous reset (`rst` high on a rising edge) clears `out_valid`, `gray_q` and `bin_q` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Thermometer code is offered |
| in_ready | output | 1 | Stage can accept a code this cycle |
| thermo | input | TAPS (31) | Thermometer taps, indexed [TAPS:1]; bit j is tap Tj |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| gray_q | output | NBITS (5) | Registered Gray word |
| bin_q | output | NBITS (5) | Registered binary word |

## Verification
The bench builds the block with its default parameter, NBITS = 5, which gives 31 taps. At this size all 32 clean levels, and every adjacent pair of levels, can be checked exhaustively against a ones-counting reference.

The same width keeps the random bubbled codes meaningful. Each Gray bit can be checked against the product equations, and single bubbles can be placed in every tap above the middle one, over every clean code below it.

Directed stall and reset sequences exercise the holding and clearing behaviour of the single output register.

// File: rtl/thermo_gray_pkg.sv
package thermo_gray_pkg;
  // Number of comparator taps for an n-bit output.
  function automatic int tap_count(input int nbits);
    return (1 << nbits) - 1;
  endfunction
endpackage

// File: rtl/thermo_gray_products.sv
module thermo_gray_products #(
  parameter int NBITS = 5,
  parameter int TAPS  = (1 << NBITS) - 1
) (
  input  logic [TAPS:1]    thermo,
  output logic [NBITS-1:0] gray
);
  // Top Gray bit is the middle tap itself.
  localparam int MID = 1 << (NBITS - 1);

  assign gray[NBITS-1] = thermo[MID];

  for (genvar gi = 0; gi < NBITS - 1; gi++) begin : g_bit
    localparam int NT  = 1 << (NBITS - gi - 2);
    localparam int GAP = 1 << (gi + 1);
    localparam int PER = 1 << (gi + 2);
    logic [NT-1:0] prod;
    for (genvar gk = 0; gk < NT; gk++) begin : g_term
      localparam int LO = (1 << gi) + gk * PER;
      localparam int HI = LO + GAP;
      assign prod[gk] = thermo[LO] & ~thermo[HI];
    end
    assign gray[gi] = |prod;
  end
endmodule

// File: rtl/gray_to_bin_chain.sv
module gray_to_bin_chain #(
  parameter int NBITS = 5
) (
  input  logic [NBITS-1:0] gray,
  output logic [NBITS-1:0] bin
);
  always_comb begin
    bin[NBITS-1] = gray[NBITS-1];
    for (int i = NBITS - 2; i >= 0; i--) begin
      bin[i] = gray[i] ^ bin[i+1];
    end
  end
endmodule

// File: rtl/enc_out_stage.sv
module enc_out_stage #(
  parameter int NBITS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NBITS-1:0] gray_d,
  input  logic [NBITS-1:0] bin_d,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NBITS-1:0] gray_q,
  output logic [NBITS-1:0] bin_q
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      gray_q    <= '0;
      bin_q     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        gray_q <= gray_d;
        bin_q  <= bin_d;
      end
    end
  end
endmodule

// File: rtl/thermo_gray_encoder.sv
module thermo_gray_encoder
  import thermo_gray_pkg::*;
#(
  parameter int NBITS = 5,
  localparam int TAPS = tap_count(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAPS:1]    thermo,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NBITS-1:0] gray_q,
  output logic [NBITS-1:0] bin_q
);
  logic [NBITS-1:0] gray_c;
  logic [NBITS-1:0] bin_c;

  thermo_gray_products #(.NBITS(NBITS), .TAPS(TAPS)) u_prod (
    .thermo (thermo),
    .gray   (gray_c)
  );

  gray_to_bin_chain #(.NBITS(NBITS)) u_chain (
    .gray (gray_c),
    .bin  (bin_c)
  );

  enc_out_stage #(.NBITS(NBITS)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .gray_d    (gray_c),
    .bin_d     (bin_c),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .gray_q    (gray_q),
    .bin_q     (bin_q)
  );
endmodule

// File: rtl/thermo_gray_encoder_chk.sv
module thermo_gray_encoder_chk #(
  parameter int NBITS = 5,
  parameter int TAPS  = (1 << NBITS) - 1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [TAPS:1]    thermo,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NBITS-1:0] gray_q,
  input logic [NBITS-1:0] bin_q
);
  localparam int MID = 1 << (NBITS - 1);

  logic             clean_in;
  logic [NBITS-1:0] ones_in;
  logic             take;

  assign clean_in = ((thermo & (thermo + 1'b1)) == '0);
  assign ones_in  = NBITS'($countones(thermo));
  assign take     = in_valid & in_ready;

  // R1: clean code yields its ones count one stage later
  p_count_r1: assert property (@(posedge clk) disable iff (rst)
    take && clean_in |=> out_valid && bin_q == $past(ones_in));

  // R2: Gray and binary registers agree on clean codes
  p_gray_rel_r2: assert property (@(posedge clk) disable iff (rst)
    take && clean_in |=> gray_q == (bin_q ^ (bin_q >> 1)));

  // R4: top bits follow the middle tap
  p_top_tap_r4: assert property (@(posedge clk) disable iff (rst)
    take |=> gray_q[NBITS-1] == $past(thermo[MID]) && bin_q[NBITS-1] == $past(thermo[MID]));

  // R6: accepted code produces valid output
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  // R7: stall holds the output
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(gray_q) && $stable(bin_q));

  p_stall_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R8: reset clears the stage
  p_reset_r8: assert property (@(posedge clk)
    rst |=> !out_valid && gray_q == '0 && bin_q == '0);
endmodule

bind thermo_gray_encoder thermo_gray_encoder_chk #(.NBITS(NBITS), .TAPS(TAPS)) u_chk (.*);

// File: tb/thermo_gray_encoder_bench.sv
`timescale 1ns/1ps
module thermo_gray_encoder_bench;
  localparam int NB = 5;
  localparam int TP = (1 << NB) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [TP:1]   thermo = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [NB-1:0] gray_q;
  logic [NB-1:0] bin_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  thermo_gray_encoder #(.NBITS(NB)) u_thermo_gray_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .thermo(thermo), .out_valid(out_valid), .out_ready(out_ready),
    .gray_q(gray_q), .bin_q(bin_q)
  );

  function automatic logic [TP:1] level_code(input int k);
    logic [TP:1] c = '0;
    for (int j = 1; j <= TP; j++) c[j] = (j <= k);
    return c;
  endfunction

  function automatic logic [NB-1:0] eq_gray(input logic [TP:1] t);
    logic [NB-1:0] g = '0;
    g[NB-1] = t[1 << (NB-1)];
    for (int i = 0; i < NB - 1; i++) begin
      for (int b = (1 << i); b + (1 << (i+1)) <= TP; b += (1 << (i+2)))
        g[i] = g[i] | (t[b] & ~t[b + (1 << (i+1))]);
    end
    return g;
  endfunction

  function automatic logic [NB-1:0] eq_bin(input logic [NB-1:0] g);
    logic [NB-1:0] b;
    b[NB-1] = g[NB-1];
    for (int i = NB - 2; i >= 0; i--) b[i] = g[i] ^ b[i+1];
    return b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one code with out_ready high; sample just after the accepting edge.
  task automatic send(input logic [TP:1] c);
    @(negedge clk);
    thermo = c;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] prev_g;
    logic [TP:1]   c;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    check("R8 reset valid", 32'(out_valid), 0);
    check("R8 reset bin", 32'(bin_q), 0);
    check("R8 reset gray", 32'(gray_q), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1, R2, R3: all clean levels
    prev_g = '0;
    for (int k = 0; k <= TP; k++) begin
      send(level_code(k));
      check("R1 level bin", 32'(bin_q), 32'(k));
      check("R2 level gray", 32'(gray_q), 32'(k ^ (k >> 1)));
      check("R6 valid after accept", 32'(out_valid), 1);
      if (k > 0) check("R3 one gray bit step", 32'($countones(gray_q ^ prev_g)), 1);
      prev_g = gray_q;
    end
    check("R2 all ones gray", 32'(gray_q), 32'h10);

    // R6: valid drops when nothing offered
    @(posedge clk);
    #1;
    check("R6 valid drops", 32'(out_valid), 0);

    // R4: single bubble above middle tap over low clean codes
    for (int k = 0; k < (1 << (NB-1)); k++) begin
      for (int p = (1 << (NB-1)) + 1; p <= TP; p++) begin
        if (p > k + 1) begin
          c = level_code(k);
          c[p] = 1'b1;
          send(c);
          check("R4 bubble gray top", 32'(gray_q[NB-1]), 0);
          check("R4 bubble bin top", 32'(bin_q[NB-1]), 0);
        end
      end
    end

    // R5: random arbitrary codes against product equations
    for (int n = 0; n < 300; n++) begin
      c = TP'($urandom());
      send(c);
      check("R5 random gray", 32'(gray_q), 32'(eq_gray(c)));
      check("R5 random bin", 32'(bin_q), 32'(eq_bin(eq_gray(c))));
    end

    // R7: stall holds output and blocks input
    send(level_code(9));
    @(negedge clk);
    out_ready = 1'b0;
    thermo = level_code(22);
    in_valid = 1'b1;
    #1;
    check("R7 ready low in stall", 32'(in_ready), 0);
    @(posedge clk);
    #1;
    check("R7 held bin", 32'(bin_q), 9);
    check("R7 held valid", 32'(out_valid), 1);
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    check("R7 after release bin", 32'(bin_q), 22);

    // R8: reset mid-run
    send(level_code(17));
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R8 mid reset valid", 32'(out_valid), 0);
    check("R8 mid reset bin", 32'(bin_q), 0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule